// File: doc/BRIEF.md
# Prioritised Peripheral Interrupt Flag

This block sits between a peripheral that pulses a completion strobe and the CPU's interrupt input. Each strobe sets a sticky event flag. The flag is always recorded, even when the interrupt is masked off. Software clears the flag by writing a one to it.

A request goes to the CPU only when three things hold together:
- the flag is set;
- the local enable bit is set;
- the block's 2-bit priority level is strictly above the CPU's current 2-bit mask level.

The request is combinational from the registered state and the mask input. It therefore tracks a change of mask at once. A fixed exception vector address comes with the request.

Software reaches the enable, the priority and the flag through a small register bus. Writes are synchronous. The read data is combinational from the address.

Top module: `irq_flag_ctrl`

## Requirements
- R1: After reset the flag, the enable bit and the priority are all 0, `irq_o` is 0, and both registers read as 0.
- R2: A high `done_i` at a rising clock edge sets the flag to 1. This happens whatever the values of the enable bit and the priority. The flag reads as bit 0 of the status register at address 1.
- R3: A write to address 1 with bit 0 of the write data at 1 clears the flag to 0 at that edge.
- R4: A write to address 1 with bit 0 of the write data at 0 leaves the flag unchanged.
- R5: When `done_i` and a clearing write to address 1 occur at the same edge, the flag ends at 1.
- R6: `irq_o` is 1 exactly when the flag is 1, the enable bit is 1, and the priority is strictly greater than `cpu_mask_i`. When the priority equals the mask, `irq_o` is 0.
- R7: With the enable bit at 0, `irq_o` stays 0 while the flag still gets set.
- R8: A priority of 0 never raises `irq_o`, for any mask level.
- R9: `vector_o` is the constant 24'h000026.
- R10: The control register is at address 0. Bit 0 is the enable and bits 2:1 are the priority. Unused bits read as 0. Addresses other than 0 and 1 read as 0.
- R11: `irq_o` falls in the same cycle as a rise of `cpu_mask_i` to or above the priority, with no clock edge needed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| done_i | input | 1 | Peripheral completion strobe |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 2 | Register address |
| reg_wdata_i | input | 8 | Write data |
| reg_rdata_o | output | 8 | Read data, combinational from the address |
| cpu_mask_i | input | 2 | CPU's current interrupt mask level |
| irq_o | output | 1 | Interrupt request to the CPU |
| vector_o | output | 24 | Exception vector address |

## Verification
Flag, enable and priority changes register at the edge where `done_i` or the write is presented. They are due one edge later. The bench drives at the falling edge, lets one rising edge pass, and reads back at the next falling edge. The request and the read data are combinational from that state and the current mask, so they are sampled a short delay after any input change without waiting for a clock. The mask-drop check in R11 changes only the mask and samples before any clock edge.

// File: rtl/irq_pkg.sv
package irq_pkg;
  parameter int unsigned ADDR_W = 2;
  parameter int unsigned DATA_W = 8;
  parameter int unsigned PRIO_W = 2;
  parameter int unsigned VEC_W  = 24;

  localparam logic [ADDR_W-1:0] CTRL_ADDR = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] STAT_ADDR = ADDR_W'(1);

  // control register field positions
  localparam int unsigned EN_BIT  = 0;
  localparam int unsigned PRIO_LO = 1;

  typedef logic [PRIO_W-1:0] prio_t;
endpackage

// File: rtl/irq_flag_cell.sv
module irq_flag_cell (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  output logic flag_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     flag_o <= 1'b0;
    else if (set_i)  flag_o <= 1'b1;   // set wins over clear
    else if (clr_i)  flag_o <= 1'b0;
  end

  assert_set_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_i |=> flag_o);
  assert_clear_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && !set_i) |=> !flag_o);
  assert_hold_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_i && !set_i) |=> $stable(flag_o));
endmodule

// File: rtl/irq_cfg_regs.sv
module irq_cfg_regs
  import irq_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              flag_i,
  output logic              en_o,
  output prio_t             prio_o,
  output logic              flag_clr_o,
  output logic [DATA_W-1:0] rdata_o
);
  logic ctrl_we;
  assign ctrl_we    = wr_i && (addr_i == CTRL_ADDR);
  assign flag_clr_o = wr_i && (addr_i == STAT_ADDR) && wdata_i[0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_o   <= 1'b0;
      prio_o <= '0;
    end else if (ctrl_we) begin
      en_o   <= wdata_i[EN_BIT];
      prio_o <= wdata_i[PRIO_LO +: PRIO_W];
    end
  end

  always_comb begin
    rdata_o = '0;
    if (addr_i == CTRL_ADDR) begin
      rdata_o[EN_BIT]              = en_o;
      rdata_o[PRIO_LO +: PRIO_W]   = prio_o;
    end else if (addr_i == STAT_ADDR) begin
      rdata_o[0] = flag_i;
    end
  end

  assert_ctrl_wr_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl_we |=> (en_o == $past(wdata_i[EN_BIT])) &&
                (prio_o == $past(wdata_i[PRIO_LO +: PRIO_W])));
endmodule

// File: rtl/irq_prio_gate.sv
module irq_prio_gate
  import irq_pkg::*;
(
  input  logic  flag_i,
  input  logic  en_i,
  input  prio_t prio_i,
  input  prio_t mask_i,
  output logic  req_o
);
  // strictly above mask; level 0 can never win
  assign req_o = flag_i && en_i && (prio_i > mask_i);
endmodule

// File: rtl/irq_flag_ctrl.sv
module irq_flag_ctrl
  import irq_pkg::*;
#(
  parameter logic [VEC_W-1:0] VECTOR = 24'h000026
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              done_i,
  input  logic              reg_wr_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [DATA_W-1:0] reg_wdata_i,
  output logic [DATA_W-1:0] reg_rdata_o,
  input  logic [PRIO_W-1:0] cpu_mask_i,
  output logic              irq_o,
  output logic [VEC_W-1:0]  vector_o
);
  logic  flag, en, flag_clr;
  prio_t prio;

  irq_flag_cell u_flag (
    .clk_i (clk_i), .rst_ni(rst_ni),
    .set_i (done_i), .clr_i(flag_clr), .flag_o(flag)
  );

  irq_cfg_regs u_regs (
    .clk_i (clk_i), .rst_ni(rst_ni),
    .wr_i  (reg_wr_i), .addr_i(reg_addr_i), .wdata_i(reg_wdata_i),
    .flag_i(flag), .en_o(en), .prio_o(prio),
    .flag_clr_o(flag_clr), .rdata_o(reg_rdata_o)
  );

  irq_prio_gate u_gate (
    .flag_i(flag), .en_i(en), .prio_i(prio),
    .mask_i(cpu_mask_i), .req_o(irq_o)
  );

  assign vector_o = VECTOR;

  assert_set_wins_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_i && flag_clr) |=> flag);
  assert_en_gate_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en |-> !irq_o);
  assert_lvl0_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (prio == '0) |-> !irq_o);
  assert_req_cond_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (flag && prio > cpu_mask_i));
endmodule

// File: tb/sim_irq_flag_ctrl.sv
`timescale 1ns/1ps
module sim_irq_flag_ctrl;
  logic clk = 1'b0, rst_n = 1'b0;
  logic done = 1'b0, wr = 1'b0;
  logic [1:0] addr = 2'd0, mask = 2'd0;
  logic [7:0] wdata = 8'h00, rdata;
  logic irq;
  logic [23:0] vec;
  int checks = 0, errors = 0;
  bit  finished = 1'b0;

  always #10 clk = ~clk; // 50 MHz

  irq_flag_ctrl u0 (
    .clk_i(clk), .rst_ni(rst_n), .done_i(done), .reg_wr_i(wr),
    .reg_addr_i(addr), .reg_wdata_i(wdata), .reg_rdata_o(rdata),
    .cpu_mask_i(mask), .irq_o(irq), .vector_o(vec)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // {done, wr, addr[1:0], wdata[7:0], mask[1:0], exp_flag, exp_irq}
  localparam int N = 12;
  localparam logic [15:0] VECS [N] = '{
    {1'b1, 1'b0, 2'd0, 8'h00, 2'd0, 1'b1, 1'b0}, // R2 R7 set with enable off
    {1'b0, 1'b1, 2'd0, 8'h07, 2'd0, 1'b1, 1'b1}, // R6 en=1 prio=3
    {1'b0, 1'b0, 2'd0, 8'h00, 2'd2, 1'b1, 1'b1}, // R6 3>2
    {1'b0, 1'b0, 2'd0, 8'h00, 2'd3, 1'b1, 1'b0}, // R6 equal blocks
    {1'b0, 1'b1, 2'd1, 8'h00, 2'd1, 1'b1, 1'b1}, // R4 write 0
    {1'b0, 1'b1, 2'd1, 8'h01, 2'd1, 1'b0, 1'b0}, // R3 write 1 clears
    {1'b1, 1'b1, 2'd0, 8'h05, 2'd1, 1'b1, 1'b1}, // R2 prio=2 >1
    {1'b0, 1'b0, 2'd0, 8'h00, 2'd2, 1'b1, 1'b0}, // R6 equal
    {1'b0, 1'b1, 2'd0, 8'h01, 2'd0, 1'b1, 1'b0}, // R8 prio 0
    {1'b0, 1'b1, 2'd0, 8'h03, 2'd0, 1'b1, 1'b1}, // R6 prio1 >0
    {1'b1, 1'b1, 2'd1, 8'h01, 2'd0, 1'b1, 1'b1}, // R5 set wins
    {1'b0, 1'b1, 2'd0, 8'h02, 2'd0, 1'b1, 1'b0}  // R7 enable off
  };

  initial begin
    #1_000_000;
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    #1;
    // R1 reset state
    chk("R1 irq", irq, 0);
    addr = 2'd0; #1 chk("R1 ctrl", rdata, 8'h00);
    addr = 2'd1; #1 chk("R1 flag", rdata, 8'h00);
    rst_n = 1'b1;
    chk("R9 vector", vec, 24'h000026);

    for (int i = 0; i < N; i++) begin
      @(negedge clk);
      {done, wr, addr, wdata, mask} = VECS[i][15:2];
      @(negedge clk);
      done = 1'b0; wr = 1'b0; addr = 2'd1;
      #1;
      chk($sformatf("R2-set/R3-clear row%0d flag", i), rdata[0], VECS[i][1]);
      chk($sformatf("R6 row%0d irq", i), irq, VECS[i][0]);
    end

    // R10 readback and unused bits
    @(negedge clk);
    wr = 1'b1; addr = 2'd0; wdata = 8'hFF;
    @(negedge clk);
    wr = 1'b0; #1;
    chk("R10 ctrl readback", rdata, 8'h07);
    addr = 2'd2; #1 chk("R10 unused addr", rdata, 8'h00);
    addr = 2'd3; #1 chk("R10 unused addr3", rdata, 8'h00);

    // R11 mask rise drops request without a clock
    mask = 2'd0; #1 chk("R11 irq before", irq, 1);
    mask = 2'd3; #1 chk("R11 irq after mask rise", irq, 0);
    mask = 2'd2; #1 chk("R11 irq mask below", irq, 1);

    // R8 level 0 across all masks
    @(negedge clk);
    wr = 1'b1; addr = 2'd0; wdata = 8'h01;
    @(negedge clk);
    wr = 1'b0;
    for (int m = 0; m < 4; m++) begin
      mask = 2'(m); #1 chk("R8 prio0 irq", irq, 0);
    end

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule